// File: doc/BRIEF.md
# IDE PIO Single-Sector Transfer Sequencer

This block moves one 512-byte sector between a user word stream and an IDE/ATA drive using programmed I/O. It needs no host software. A single start pulse captures a sector number, cylinder, head, drive select, a direction and a retry choice. The sequencer then writes the drive's command-block registers in a fixed order and issues the matching sector command. It polls the status register until the busy flag drops, and then moves 256 sixteen-bit words through the data register.

On the user side, read data comes out on a valid/ready stream and write data is taken from another valid/ready stream. Flow control on either stream stretches the drive transfer without breaking the protocol. When the drive reports an error, the block reads the drive's error register and returns that value. When the drive stays busy too long, the block gives up with a timeout flag.

Every drive access has the same shape. The address and chip select are set up for one cycle. A read or write strobe is then held low for a parameterised number of cycles, followed by one hold cycle.

Top module: `ide_sector_seq`

## Requirements
- R1: After reset, both strobes and both chip selects are high (inactive), and `seq_busy`, `done`, `fail`, `rd_valid` and `wr_ready` are low.
- R2: After an accepted start, the block makes six register writes in this order: offset 2 with value 0x01, offset 3 with the sector number, offset 4 with cylinder bits 7:0, offset 5 with cylinder bits 15:8, offset 6 with the drive/head byte, and offset 7 with the command. The upper data byte is zero on each of these writes.
- R3: The drive/head byte is 1,0,1 in bits 7:5, the drive select in bit 4 and the head number in bits 3:0.
- R4: The command byte is 0x20 for a read with retry, 0x21 for a read without retry, 0x30 for a write with retry and 0x31 for a write without retry.
- R5: `ide_cs1_n` never goes low. `ide_cs0_n` is low whenever a strobe is low, and the address does not change while a strobe is low.
- R6: After the command write, the block reads the status register (offset 7) again and again while status bit 7 is set. No data-register access happens before a status read returns bit 7 clear.
- R7: When that status read also has bit 0 clear, exactly 256 accesses to offset 0 follow, in the selected direction. Read words appear on `rd_data` in the order they were read, and write words go to the drive in the order they were accepted.
- R8: A data write strobe happens only for a word already accepted on the write stream. A data read is not started until the previous read word has been taken (`rd_valid` and `rd_ready` both high). While not taken, `rd_data` and `rd_valid` hold steady.
- R9: When the first not-busy status read has bit 0 set, the block reads offset 1 and then raises `fail` for one cycle. `fail_code` carries the byte read, `fail_timeout` is low, and no data access follows.
- R10: When `POLL_LIMIT` status reads in a row all return bit 7 set, the block raises `fail` with `fail_timeout` high and `fail_code` equal to the last status byte, and makes no further access.
- R11: After a successful transfer, `done` is high for exactly one cycle, after the last data access has completed and, for a read, after the last word has been taken. `done` and `fail` are never high together.
- R12: Each access holds the chip select low for one cycle before the strobe falls. The strobe then stays low for exactly `STB_CYC` cycles, and the chip select stays low for one more cycle after the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer; accepted only when idle |
| op_write | input | 1 | 1 = write sector, 0 = read sector |
| no_retry | input | 1 | Select the command variant without retry |
| drive_sel | input | 1 | Drive select placed in bit 4 of the drive/head byte |
| head | input | 4 | Head number |
| sector | input | 8 | Sector number |
| cylinder | input | 16 | Cylinder number |
| seq_busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| fail | output | 1 | One-cycle pulse on drive error or timeout |
| fail_timeout | output | 1 | The last failure was a busy timeout |
| fail_code | output | 8 | Error register value, or last status on timeout |
| wr_data | input | 16 | Write stream word |
| wr_valid | input | 1 | Write stream word valid |
| wr_ready | output | 1 | Sequencer accepts a write word |
| rd_data | output | 16 | Read stream word |
| rd_valid | output | 1 | Read stream word valid |
| rd_ready | input | 1 | Consumer accepts the read word |
| ide_addr | output | 3 | Drive register offset |
| ide_cs0_n | output | 1 | Command-block chip select, active low |
| ide_cs1_n | output | 1 | Control-block chip select, active low |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_dout | output | 16 | Data driven toward the drive |
| ide_doe | output | 1 | Drive-side output enable for `ide_dout` |
| ide_din | input | 16 | Data returned by the drive |

## Verification
The bench builds the block with `STB_CYC` = 2 and `POLL_LIMIT` = 6, and keeps the full 256-word sector. The short poll limit means the timeout can be reached after six status reads, so the timeout path and the exact count of its polls are both exercised. The two-cycle strobe shows that the strobe width is set by the parameter rather than being fixed at one cycle. The bench also stalls the read stream on every third cycle and the write stream on every fourth, which tests the flow-control stall in both directions on a full sector.

// File: rtl/ide_seq_pkg.sv
// Shared constants, types and helpers for the IDE sector sequencer.
// Assumes a 16-bit drive data bus and 8-bit task-file registers.
package ide_seq_pkg;
    timeunit 1ns; timeprecision 100ps;

    localparam int DATA_W = 16;

    // Command-block register offsets; the programming order relies on 2..7 being contiguous
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_ERR   = 3'd1;
    localparam logic [2:0] OFS_FIRST = 3'd2;
    localparam logic [2:0] OFS_STAT  = 3'd7;

    localparam int BIT_BUSY = 7;
    localparam int BIT_ERR  = 0;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_PROG, SQ_POLL, SQ_ERRRD, SQ_XFER
    } seq_state_t;

    typedef enum logic [1:0] {
        BC_IDLE, BC_SETUP, BC_STROBE, BC_HOLD
    } bus_state_t;

    typedef struct packed {
        logic [2:0]        addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

    function automatic logic [7:0] drv_head_byte(input logic drv, input logic [3:0] hd);
        return {3'b101, drv, hd};
    endfunction

    function automatic logic [7:0] sector_cmd(input logic wr, input logic noretry);
        return wr ? (noretry ? 8'h31 : 8'h30) : (noretry ? 8'h21 : 8'h20);
    endfunction
endpackage

// File: rtl/ide_step_counter.sv
// Saturating-free up counter with a terminal flag.
// Assumes the user never increments while 'last' is high; clear has priority.
module ide_step_counter #(
    parameter int LIMIT = 6,
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic          last,
    output logic [CW-1:0] value
);
    timeunit 1ns; timeprecision 100ps;

    // Count register: clear, step, or hold
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (clr) value <= '0;
        else if (inc) value <= value + 1'b1;
    end

    // Terminal count indicator
    always_comb last = (value == CW'(LIMIT - 1));

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        value <= CW'(LIMIT - 1));
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> !last);
endmodule

// File: rtl/ide_bus_cycle.sv
// Runs one drive register access: setup cycle, STB_CYC strobe cycles, hold cycle.
// Assumes the requester presents a request only while 'busy' is low; read data
// is captured on the last strobe cycle and is valid while 'ack' is high.
module ide_bus_cycle
    import ide_seq_pkg::*;
#(
    parameter int STB_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  bus_req_t          req,
    output logic              busy,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [2:0]        ide_addr,
    output logic              ide_cs0_n,
    output logic              ide_cs1_n,
    output logic              ide_rd_n,
    output logic              ide_wr_n,
    output logic [DATA_W-1:0] ide_dout,
    output logic              ide_doe,
    input  logic [DATA_W-1:0] ide_din
);
    timeunit 1ns; timeprecision 100ps;

    localparam int SW = $clog2(STB_CYC + 1);

    bus_state_t      st;
    bus_req_t        cur;
    logic [SW-1:0]   scnt;

    // Access phase sequencing and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= BC_IDLE;
            cur   <= '0;
            scnt  <= '0;
            rdata <= '0;
        end else begin
            case (st)
                BC_IDLE: if (req_valid) begin
                    cur <= req;
                    st  <= BC_SETUP;
                end
                BC_SETUP: begin
                    scnt <= '0;
                    st   <= BC_STROBE;
                end
                BC_STROBE: begin
                    if (scnt == SW'(STB_CYC - 1)) begin
                        if (!cur.wr) rdata <= ide_din;
                        st <= BC_HOLD;
                    end else begin
                        scnt <= scnt + 1'b1;
                    end
                end
                default: st <= BC_IDLE;
            endcase
        end
    end

    // Pin drive from the phase register
    always_comb begin
        busy      = (st != BC_IDLE);
        ack       = (st == BC_HOLD);
        ide_addr  = cur.addr;
        ide_cs0_n = (st == BC_IDLE);
        ide_cs1_n = 1'b1;
        ide_rd_n  = !((st == BC_STROBE) && !cur.wr);
        ide_wr_n  = !((st == BC_STROBE) && cur.wr);
        ide_dout  = cur.wdata;
        ide_doe   = busy && cur.wr;
    end

    logic strobe_idle;
    always_comb strobe_idle = ide_rd_n && ide_wr_n;

    assert_setup_before_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_idle) |-> $past(!ide_cs0_n));
    assert_hold_after_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_idle) |-> !ide_cs0_n);
    assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_idle && $past(!strobe_idle)) |-> $stable(ide_addr));
endmodule

// File: rtl/ide_seq_ctrl.sv
// Sequencer control: register programming, busy poll, error fetch and data phase.
// Assumes the bus engine accepts a request in the cycle req_valid is high with
// bus_busy low, and raises bus_ack for one cycle when the access ends.
module ide_seq_ctrl
    import ide_seq_pkg::*;
#(
    parameter int STEP_W = 3,
    parameter int POLL_W = 3,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_write,
    input  logic              no_retry,
    input  logic              drive_sel,
    input  logic [3:0]        head,
    input  logic [7:0]        sector,
    input  logic [15:0]       cylinder,
    output logic              seq_busy,
    output logic              done,
    output logic              fail,
    output logic              fail_timeout,
    output logic [7:0]        fail_code,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              req_valid,
    output bus_req_t          req,
    input  logic              bus_busy,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [STEP_W-1:0] step_val,
    input  logic              step_last,
    input  logic [POLL_W-1:0] poll_val,
    input  logic              poll_last,
    input  logic [WORD_W-1:0] word_val,
    input  logic              word_last,
    output logic              cnt_clr,
    output logic              step_inc,
    output logic              poll_inc,
    output logic              word_inc
);
    timeunit 1ns; timeprecision 100ps;

    seq_state_t  state;
    logic        op_wr_q, noretry_q, drv_q;
    logic [3:0]  head_q;
    logic [7:0]  sect_q;
    logic [15:0] cyl_q;
    logic        rd_hold;
    logic [7:0]  prog_byte;

    // Byte for the current programming step
    always_comb begin
        case (step_val)
            STEP_W'(0): prog_byte = 8'h01;
            STEP_W'(1): prog_byte = sect_q;
            STEP_W'(2): prog_byte = cyl_q[7:0];
            STEP_W'(3): prog_byte = cyl_q[15:8];
            STEP_W'(4): prog_byte = drv_head_byte(drv_q, head_q);
            STEP_W'(5): prog_byte = sector_cmd(op_wr_q, noretry_q);
            default:    prog_byte = 8'h00;
        endcase
    end

    // Bus request and stream handshakes for the current state
    always_comb begin
        req_valid = 1'b0;
        req       = '0;
        wr_ready  = 1'b0;
        case (state)
            SQ_PROG: begin
                req_valid = !bus_busy;
                req.addr  = 3'(OFS_FIRST + 3'(step_val));
                req.wr    = 1'b1;
                req.wdata = {8'h00, prog_byte};
            end
            SQ_POLL: begin
                req_valid = !bus_busy;
                req.addr  = OFS_STAT;
            end
            SQ_ERRRD: begin
                req_valid = !bus_busy;
                req.addr  = OFS_ERR;
            end
            SQ_XFER: begin
                req.addr = OFS_DATA;
                if (op_wr_q) begin
                    wr_ready  = !bus_busy;
                    req_valid = !bus_busy && wr_valid;
                    req.wr    = 1'b1;
                    req.wdata = wr_data;
                end else begin
                    req_valid = !bus_busy && !rd_hold;
                end
            end
            default: ;
        endcase
    end

    // Counter controls
    always_comb begin
        cnt_clr  = (state == SQ_IDLE) && start;
        step_inc = (state == SQ_PROG) && bus_ack && !step_last;
        poll_inc = (state == SQ_POLL) && bus_ack && bus_rdata[BIT_BUSY] && !poll_last;
        word_inc = (state == SQ_XFER) && !word_last &&
                   (op_wr_q ? bus_ack : (rd_hold && rd_ready));
    end

    always_comb begin
        seq_busy = (state != SQ_IDLE);
        rd_valid = rd_hold;
    end

    // Main sequence, completion pulses and read-word holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= SQ_IDLE;
            op_wr_q      <= 1'b0;
            noretry_q    <= 1'b0;
            drv_q        <= 1'b0;
            head_q       <= '0;
            sect_q       <= '0;
            cyl_q        <= '0;
            done         <= 1'b0;
            fail         <= 1'b0;
            fail_timeout <= 1'b0;
            fail_code    <= '0;
            rd_hold      <= 1'b0;
            rd_data      <= '0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    op_wr_q      <= op_write;
                    noretry_q    <= no_retry;
                    drv_q        <= drive_sel;
                    head_q       <= head;
                    sect_q       <= sector;
                    cyl_q        <= cylinder;
                    fail_timeout <= 1'b0;
                    fail_code    <= '0;
                    state        <= SQ_PROG;
                end
                SQ_PROG: if (bus_ack && step_last) state <= SQ_POLL;
                SQ_POLL: if (bus_ack) begin
                    if (bus_rdata[BIT_BUSY]) begin
                        if (poll_last) begin
                            fail         <= 1'b1;
                            fail_timeout <= 1'b1;
                            fail_code    <= bus_rdata[7:0];
                            state        <= SQ_IDLE;
                        end
                    end else if (bus_rdata[BIT_ERR]) begin
                        state <= SQ_ERRRD;
                    end else begin
                        state <= SQ_XFER;
                    end
                end
                SQ_ERRRD: if (bus_ack) begin
                    fail      <= 1'b1;
                    fail_code <= bus_rdata[7:0];
                    state     <= SQ_IDLE;
                end
                SQ_XFER: begin
                    if (op_wr_q) begin
                        if (bus_ack && word_last) begin
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                        end
                    end else if (bus_ack) begin
                        rd_hold <= 1'b1;
                        rd_data <= bus_rdata;
                    end else if (rd_hold && rd_ready) begin
                        rd_hold <= 1'b0;
                        if (word_last) begin
                            done  <= 1'b1;
                            state <= SQ_IDLE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    assert_done_fail_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
    assert_timeout_with_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_timeout) |-> fail);
    assert_word_idx_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PROG) |-> (word_val == '0));
    assert_poll_idx_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PROG) |-> (poll_val == '0));
endmodule

// File: rtl/ide_sector_seq.sv
// Top level: single-sector PIO read/write sequencer for an IDE command block.
// Assumes the drive honours the strobe width STB_CYC; POLL_LIMIT bounds busy polls.
module ide_sector_seq
    import ide_seq_pkg::*;
#(
    parameter int STB_CYC    = 3,
    parameter int POLL_LIMIT = 100000,
    parameter int WORDS      = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_write,
    input  logic        no_retry,
    input  logic        drive_sel,
    input  logic [3:0]  head,
    input  logic [7:0]  sector,
    input  logic [15:0] cylinder,
    output logic        seq_busy,
    output logic        done,
    output logic        fail,
    output logic        fail_timeout,
    output logic [7:0]  fail_code,
    input  logic [15:0] wr_data,
    input  logic        wr_valid,
    output logic        wr_ready,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    input  logic        rd_ready,
    output logic [2:0]  ide_addr,
    output logic        ide_cs0_n,
    output logic        ide_cs1_n,
    output logic        ide_rd_n,
    output logic        ide_wr_n,
    output logic [15:0] ide_dout,
    output logic        ide_doe,
    input  logic [15:0] ide_din
);
    timeunit 1ns; timeprecision 100ps;

    localparam int PROG_STEPS = 6;
    localparam int STEP_W = cnt_width(PROG_STEPS);
    localparam int POLL_W = cnt_width(POLL_LIMIT);
    localparam int WORD_W = cnt_width(WORDS);

    logic              req_valid, bus_busy, bus_ack;
    bus_req_t          req;
    logic [DATA_W-1:0] bus_rdata;
    logic              cnt_clr, step_inc, poll_inc, word_inc;
    logic              step_last, poll_last, word_last;
    logic [STEP_W-1:0] step_val;
    logic [POLL_W-1:0] poll_val;
    logic [WORD_W-1:0] word_val;

    ide_seq_ctrl #(.STEP_W(STEP_W), .POLL_W(POLL_W), .WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
        .no_retry(no_retry), .drive_sel(drive_sel), .head(head),
        .sector(sector), .cylinder(cylinder), .seq_busy(seq_busy),
        .done(done), .fail(fail), .fail_timeout(fail_timeout),
        .fail_code(fail_code), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .req_valid(req_valid), .req(req),
        .bus_busy(bus_busy), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .step_val(step_val), .step_last(step_last),
        .poll_val(poll_val), .poll_last(poll_last),
        .word_val(word_val), .word_last(word_last),
        .cnt_clr(cnt_clr), .step_inc(step_inc),
        .poll_inc(poll_inc), .word_inc(word_inc)
    );

    ide_step_counter #(.LIMIT(PROG_STEPS)) u_step (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(step_inc),
        .last(step_last), .value(step_val)
    );

    ide_step_counter #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(poll_inc),
        .last(poll_last), .value(poll_val)
    );

    ide_step_counter #(.LIMIT(WORDS)) u_word (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(word_inc),
        .last(word_last), .value(word_val)
    );

    ide_bus_cycle #(.STB_CYC(STB_CYC)) u_bus (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req(req),
        .busy(bus_busy), .ack(bus_ack), .rdata(bus_rdata),
        .ide_addr(ide_addr), .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
        .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n), .ide_dout(ide_dout),
        .ide_doe(ide_doe), .ide_din(ide_din)
    );

    assert_no_dual_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ide_cs0_n && !ide_cs1_n));
    assert_strobe_needs_cs0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_rd_n || !ide_wr_n) |-> !ide_cs0_n);
endmodule

// File: tb/ide_sector_seq_test.sv
// Bench: behavioural drive model plus an expected-access queue, checked every clock.
module ide_sector_seq_test;
    timeunit 1ns; timeprecision 100ps;

    localparam int STB  = 2;
    localparam int PLIM = 6;
    localparam int NW   = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start = 0, op_write = 0, no_retry = 0, drive_sel = 0;
    logic [3:0]  head = 0;
    logic [7:0]  sector = 0;
    logic [15:0] cylinder = 0;
    logic        seq_busy, done, fail, fail_timeout;
    logic [7:0]  fail_code;
    logic [15:0] wr_data = 0;
    logic        wr_valid = 0, wr_ready;
    logic [15:0] rd_data;
    logic        rd_valid, rd_ready = 0;
    logic [2:0]  ide_addr;
    logic        ide_cs0_n, ide_cs1_n, ide_rd_n, ide_wr_n, ide_doe;
    logic [15:0] ide_dout;
    logic [15:0] ide_din = 0;

    ide_sector_seq #(.STB_CYC(STB), .POLL_LIMIT(PLIM), .WORDS(NW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
        .no_retry(no_retry), .drive_sel(drive_sel), .head(head),
        .sector(sector), .cylinder(cylinder), .seq_busy(seq_busy),
        .done(done), .fail(fail), .fail_timeout(fail_timeout),
        .fail_code(fail_code), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .ide_addr(ide_addr), .ide_cs0_n(ide_cs0_n),
        .ide_cs1_n(ide_cs1_n), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
        .ide_dout(ide_dout), .ide_doe(ide_doe), .ide_din(ide_din)
    );

    typedef struct { bit wr; bit [2:0] a; bit [15:0] d; bit chk; string rq; } acc_t;
    acc_t expq[$];

    int checks = 0, errors = 0, cyc = 0;
    int busy_left = 0;
    logic [7:0] stat_final = 8'h58, err_val = 8'h00;
    int rd_idx = 0, rd_acc = 0, wr_taken = 0, wr_seen = 0;
    int done_cnt = 0, fail_cnt = 0, lowcnt = 0;
    bit prev_low = 0, prev_cs0_low = 0, prev_done = 0, rd_bp = 0, active = 0, finished = 0;

    function automatic logic [15:0] rpat(input int k);
        return 16'((k * 16'h0101) ^ 16'h3C5A);
    endfunction
    function automatic logic [15:0] wpat(input int k);
        return 16'(k * 7 + 16'h9100);
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    // Per-clock monitor, drive model and stream stimulus
    always @(negedge clk) begin
        bit low;
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (rst_n) begin
            low = !ide_rd_n || !ide_wr_n;
            if (ide_cs1_n !== 1'b1) check(0, "R5", "cs1 asserted", ide_cs1_n, 1);
            if (low && ide_cs0_n) check(0, "R5", "strobe without cs0", ide_cs0_n, 0);
            if (!ide_rd_n && !ide_wr_n) check(0, "R12", "both strobes", 0, 1);
            if (low) begin
                lowcnt++;
                if (!prev_low) begin
                    acc_t e;
                    check(prev_cs0_low, "R12", "setup cycle before strobe", prev_cs0_low, 1);
                    if (expq.size() == 0) begin
                        check(0, "R9", "unexpected access at offset", ide_addr, 8);
                    end else begin
                        e = expq.pop_front();
                        check(e.wr == !ide_wr_n, e.rq, "direction", !ide_wr_n, e.wr);
                        check(e.a == ide_addr, e.rq, "offset", ide_addr, e.a);
                        if (e.chk) check(e.d == ide_dout, e.rq, "write data", ide_dout, e.d);
                    end
                    if (!ide_rd_n) begin
                        case (ide_addr)
                            3'd7: begin
                                ide_din = (busy_left > 0) ? 16'h0080 : {8'h00, stat_final};
                                if (busy_left > 0) busy_left--;
                            end
                            3'd1: ide_din = {8'h00, err_val};
                            3'd0: begin
                                check(rd_acc == rd_idx, "R8", "read before word taken", rd_acc, rd_idx);
                                ide_din = rpat(rd_idx);
                                rd_idx++;
                            end
                            default: ide_din = 16'hDEAD;
                        endcase
                    end else if (ide_addr == 3'd0) begin
                        check(wr_seen < wr_taken, "R8", "write strobe without word", wr_seen, wr_taken);
                        wr_seen++;
                    end
                end
            end else if (prev_low) begin
                check(lowcnt == STB, "R12", "strobe width", lowcnt, STB);
                check(!ide_cs0_n, "R12", "cs0 hold after strobe", ide_cs0_n, 0);
                lowcnt = 0;
            end
            prev_low = low;
            prev_cs0_low = !ide_cs0_n;

            if (done) begin
                done_cnt++;
                check(!prev_done, "R11", "done wider than one cycle", 1, 0);
                check(expq.size() == 0, "R11", "done before last access", expq.size(), 0);
                check(!fail, "R11", "done with fail", fail, 0);
            end
            if (fail) begin
                fail_cnt++;
                check(expq.size() == 0, "R9", "fail before expected accesses", expq.size(), 0);
            end
            prev_done = done;

            rd_ready = rd_bp ? ((cyc % 3) != 0) : 1'b1;
            if (rd_valid && rd_ready) begin
                check(rd_data == rpat(rd_acc), "R7", "read stream word", rd_data, rpat(rd_acc));
                rd_acc++;
            end
            wr_valid = active && op_write && ((cyc % 4) != 1) && (wr_taken < NW);
            wr_data  = wpat(wr_taken);
            if (wr_valid && wr_ready) wr_taken++;
        end
    end

    // kind: 0 = success, 1 = drive error, 2 = busy timeout
    task automatic run_op(input bit wr, input bit nr, input bit drv, input logic [3:0] hd,
                          input logic [7:0] sec, input logic [15:0] cyl, input int busy_n,
                          input logic [7:0] stf, input logic [7:0] ev, input int kind,
                          input bit bp, input logic [7:0] exp_code);
        logic [7:0] cmd;
        int guard;
        cmd = wr ? (nr ? 8'h31 : 8'h30) : (nr ? 8'h21 : 8'h20);
        expq.delete();
        expq.push_back('{1, 3'd2, 16'h0001, 1, "R2"});
        expq.push_back('{1, 3'd3, {8'h00, sec}, 1, "R2"});
        expq.push_back('{1, 3'd4, {8'h00, cyl[7:0]}, 1, "R2"});
        expq.push_back('{1, 3'd5, {8'h00, cyl[15:8]}, 1, "R2"});
        expq.push_back('{1, 3'd6, {8'h00, 3'b101, drv, hd}, 1, "R3"});
        expq.push_back('{1, 3'd7, {8'h00, cmd}, 1, "R4"});
        for (int i = 0; i < ((kind == 2) ? PLIM : busy_n + 1); i++)
            expq.push_back('{0, 3'd7, 16'h0, 0, (kind == 2) ? "R10" : "R6"});
        if (kind == 1) expq.push_back('{0, 3'd1, 16'h0, 0, "R9"});
        if (kind == 0)
            for (int k = 0; k < NW; k++)
                expq.push_back('{wr, 3'd0, wr ? wpat(k) : 16'h0, wr, "R7"});
        busy_left = busy_n; stat_final = stf; err_val = ev;
        rd_idx = 0; rd_acc = 0; wr_taken = 0; wr_seen = 0; done_cnt = 0; fail_cnt = 0;
        rd_bp = bp;
        op_write = wr; no_retry = nr; drive_sel = drv; head = hd; sector = sec; cylinder = cyl;
        @(negedge clk); active = 1; start = 1;
        @(negedge clk); start = 0;
        check(seq_busy, "R2", "busy after start", seq_busy, 1);
        guard = 0;
        while (seq_busy && guard < 20000) begin @(negedge clk); guard++; end
        @(negedge clk); @(negedge clk);
        active = 0;
        check(expq.size() == 0, (kind == 0) ? "R7" : "R9", "accesses left over", expq.size(), 0);
        check(done_cnt == (kind == 0), "R11", "done pulses", done_cnt, kind == 0);
        check(fail_cnt == (kind != 0), (kind == 2) ? "R10" : "R9", "fail pulses", fail_cnt, kind != 0);
        if (kind != 0) begin
            check(fail_code == exp_code, (kind == 2) ? "R10" : "R9", "fail_code", fail_code, exp_code);
            check(fail_timeout == (kind == 2), (kind == 2) ? "R10" : "R9", "timeout flag",
                  fail_timeout, kind == 2);
        end
        if (kind == 0 && !wr) check(rd_acc == NW, "R7", "read words delivered", rd_acc, NW);
        if (kind == 0 && wr)  check(wr_seen == NW, "R7", "words written", wr_seen, NW);
        if (kind != 0) check(rd_idx == 0 && wr_seen == 0, "R9", "data accesses after fail",
                             rd_idx + wr_seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ide_rd_n && ide_wr_n, "R1", "strobes idle", {ide_rd_n, ide_wr_n}, 2'b11);
        check(ide_cs0_n && ide_cs1_n, "R1", "selects idle", {ide_cs0_n, ide_cs1_n}, 2'b11);
        check(!seq_busy && !done && !fail, "R1", "status idle", {seq_busy, done, fail}, 0);
        check(!rd_valid && !wr_ready, "R1", "streams idle", {rd_valid, wr_ready}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R2 R3 R4 R6 R7 R8 R11: read with retry, three busy polls, read back-pressure
        run_op(0, 0, 0, 4'd3, 8'd9, 16'h0123, 3, 8'h58, 8'h00, 0, 1, 8'h00);
        // R3 R4 R7 R8: write without retry, drive 1, head 15, write stream gaps
        run_op(1, 1, 1, 4'd15, 8'd1, 16'hBEEF, 0, 8'h58, 8'h00, 0, 0, 8'h00);
        // R9: drive error after one busy poll, read without retry
        run_op(0, 1, 0, 4'd7, 8'd200, 16'h00FF, 1, 8'h51, 8'h14, 1, 0, 8'h14);
        // R10: busy never clears, write with retry
        run_op(1, 0, 1, 4'd0, 8'd5, 16'h8001, 1000, 8'h58, 8'h00, 2, 0, 8'h80);
        // R7: second read without back-pressure after a failure
        run_op(0, 0, 1, 4'd9, 8'd63, 16'h0400, 0, 8'h50, 8'h00, 0, 0, 8'h00);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule